// File: doc/BRIEF.md
# Memory Sleep Mode Controller

This block sequences a synchronous memory into and out of a low-power sleep state. A sleep request arrives asynchronously and passes through a two-flop synchroniser. While the memory is still selected, the controller waits in a pending state. Once the memory is deselected, it counts a fixed entry latency and then reports that sleep is active.

When the request falls, the controller counts a fixed exit latency. It then holds a recovery window during which no new chip-enable or address-strobe activity may start. An access-block output covers every state except normal operation, so the surrounding logic can gate new accesses with one signal. If an access is still marked busy at the moment sleep begins, a one-cycle invalid flag reports that it was interrupted. Stored contents are treated as retained during sleep.

Top module: `mem_sleep_ctrl`

## Requirements
- R1: While reset is asserted, and on the first edge after its release, `sleep_on`, `acc_block` and `acc_invalid` are all 0 and the controller is in normal operation.
- R2: The request passes through two flops before it is used. With `mem_sel`=0, a request driven before edge 1 raises `acc_block` after edge 3 and `sleep_on` after edge 5, which is an entry latency of two cycles.
- R3: `acc_block` is 1 in every state except normal operation: pending, entry, sleep, exit and recovery.
- R4: If the synchronised request is high while `mem_sel`=1, the controller waits in the pending state with `sleep_on`=0. The two-cycle entry count starts only on the edge that sees `mem_sel`=0.
- R5: If `mem_sel` returns to 1 during the entry count, the controller goes back to pending and restarts the full count after deselection.
- R6: If the synchronised request falls during the entry count, the controller returns to normal operation with no recovery window. `acc_block` is 0 on the next edge and `sleep_on` never rises.
- R7: After the synchronised request falls during sleep, `sleep_on` drops on the next edge. `acc_block` stays 1 through a two-cycle exit and a two-cycle recovery, and returns to 0 on the fourth edge after `sleep_on` dropped.
- R8: `acc_invalid` is a one-cycle pulse. It is 1 only in the cycle `sleep_on` first becomes 1, and only if `acc_busy` was 1 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Sleep request, asynchronous to `clk` |
| mem_sel | input | 1 | Memory currently selected by any chip enable |
| acc_busy | input | 1 | An access is in flight |
| sleep_on | output | 1 | Sleep state active |
| acc_block | output | 1 | New accesses and address strobes must be held off |
| acc_invalid | output | 1 | The access in flight was cut off by sleep entry (one-cycle pulse) |

## Verification
All results are counted from the edge that first samples a changed input.

- **Entry:** the request needs two synchroniser edges. `acc_block` is then due on the third edge and `sleep_on` on the fifth.
- **Exit:** `sleep_on` falls on the third edge after the request drops, and `acc_block` clears four edges after that.
- **Invalid flag:** `acc_invalid` is due on the same edge as the rise of `sleep_on`.

The bench drives each input step half a cycle before an edge and compares every output one time unit after that edge, against a per-cycle expected vector. Each expected latency is therefore checked on exactly the cycle it is due.

// File: rtl/mem_sleep_ctrl.sv
module mem_sleep_ctrl #(
  parameter int ENTRY_CYC = 2,
  parameter int EXIT_CYC  = 2,
  parameter int RECOV_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic mem_sel,
  input  logic acc_busy,
  output logic sleep_on,
  output logic acc_block,
  output logic acc_invalid
);
  localparam int MAXC = (ENTRY_CYC > EXIT_CYC) ?
                        ((ENTRY_CYC > RECOV_CYC) ? ENTRY_CYC : RECOV_CYC) :
                        ((EXIT_CYC > RECOV_CYC) ? EXIT_CYC : RECOV_CYC);
  localparam int CW = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] ENTRY_LAST = CW'(ENTRY_CYC - 1);
  localparam logic [CW-1:0] EXIT_LAST  = CW'(EXIT_CYC - 1);
  localparam logic [CW-1:0] RECOV_LAST = CW'(RECOV_CYC - 1);

  typedef enum logic [2:0] {
    ST_RUN, ST_PEND, ST_ENTER, ST_SLEEP, ST_EXIT, ST_RECOV
  } state_t;

  state_t        st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic [1:0]    sync_q;
  logic          req_s;
  logic          inv_q;

  assign req_s = sync_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], sleep_req};
  end

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    case (st)
      ST_RUN:
        if (req_s) begin
          st_nx  = mem_sel ? ST_PEND : ST_ENTER;
          cnt_nx = '0;
        end
      ST_PEND:
        if (!req_s)        st_nx = ST_RUN;
        else if (!mem_sel) begin
          st_nx  = ST_ENTER;
          cnt_nx = '0;
        end
      ST_ENTER:
        if (!req_s)       st_nx = ST_RUN;
        else if (mem_sel) st_nx = ST_PEND;
        else if (cnt == ENTRY_LAST) begin
          st_nx  = ST_SLEEP;
          cnt_nx = '0;
        end else cnt_nx = cnt + 1'b1;
      ST_SLEEP:
        if (!req_s) begin
          st_nx  = ST_EXIT;
          cnt_nx = '0;
        end
      ST_EXIT:
        if (cnt == EXIT_LAST) begin
          st_nx  = ST_RECOV;
          cnt_nx = '0;
        end else cnt_nx = cnt + 1'b1;
      ST_RECOV:
        if (cnt == RECOV_LAST) begin
          st_nx  = ST_RUN;
          cnt_nx = '0;
        end else cnt_nx = cnt + 1'b1;
      default: begin
        st_nx  = ST_RUN;
        cnt_nx = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_RUN;
      cnt   <= '0;
      inv_q <= 1'b0;
    end else begin
      st    <= st_nx;
      cnt   <= cnt_nx;
      inv_q <= (st == ST_ENTER) && (st_nx == ST_SLEEP) && acc_busy;
    end
  end

  assign sleep_on    = (st == ST_SLEEP);
  assign acc_block   = (st != ST_RUN);
  assign acc_invalid = inv_q;
endmodule

module mem_sleep_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic mem_sel,
  input logic sleep_on,
  input logic acc_block,
  input logic acc_invalid
);
  AST_SLEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_on |-> acc_block); // R3
  AST_ENTRY_PRECEDED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_on) |-> $past(acc_block)); // R2
  AST_DESELECTED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_on) |-> !$past(mem_sel)); // R4
  AST_EXIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_on) |-> acc_block ##1 acc_block); // R7
  AST_INVALID_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_invalid |-> $rose(sleep_on)); // R8
  AST_INVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_invalid |=> !acc_invalid); // R8
endmodule

bind mem_sleep_ctrl mem_sleep_ctrl_chk chk (
  .clk(clk), .rst_n(rst_n), .mem_sel(mem_sel),
  .sleep_on(sleep_on), .acc_block(acc_block), .acc_invalid(acc_invalid)
);

// File: tb/mem_sleep_ctrl_test.sv
module mem_sleep_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, mem_sel = 1'b0, acc_busy = 1'b0;
  logic sleep_on, acc_block, acc_invalid;
  int   n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  mem_sleep_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .mem_sel(mem_sel),
    .acc_busy(acc_busy), .sleep_on(sleep_on), .acc_block(acc_block),
    .acc_invalid(acc_invalid)
  );

  // {req, sel, busy, exp_sleep, exp_block, exp_invalid}
  localparam int NV = 48;
  localparam logic [5:0] VEC [NV] = '{
    6'b100_000, 6'b100_000, 6'b100_010, 6'b100_010, 6'b100_110, 6'b100_110,
    6'b000_110, 6'b000_110, 6'b000_010, 6'b000_010, 6'b000_010, 6'b000_010,
    6'b000_000, 6'b000_000,
    6'b110_000, 6'b110_000, 6'b110_010, 6'b110_010, 6'b100_010, 6'b100_010,
    6'b101_111, 6'b000_110, 6'b000_110, 6'b000_010, 6'b000_010, 6'b000_010,
    6'b000_010, 6'b000_000,
    6'b100_000, 6'b100_000, 6'b000_010, 6'b000_010, 6'b000_000,
    6'b100_000, 6'b100_000, 6'b100_010, 6'b110_010, 6'b110_010, 6'b100_010,
    6'b100_010, 6'b100_110, 6'b000_110, 6'b000_110, 6'b000_010, 6'b000_010,
    6'b000_010, 6'b000_010, 6'b000_000
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {sleep,block,invalid} actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic string req_of(input int k);
    if (k < 14)      return "R2/R7 entry-exit";
    else if (k < 21) return "R4 pending";
    else if (k < 28) return "R8/R7 invalid";
    else if (k < 33) return "R6 abort";
    else             return "R5 reselect";
  endfunction

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 check("R1 reset", {sleep_on, acc_block, acc_invalid}, 3'b000);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 check("R1 after release", {sleep_on, acc_block, acc_invalid}, 3'b000);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      {sleep_req, mem_sel, acc_busy} = VEC[k][5:3];
      @(posedge clk);
      #1 check(req_of(k), {sleep_on, acc_block, acc_invalid}, VEC[k][2:0]);
    end

    // R3: pending state blocks even with selection held for long
    @(negedge clk); sleep_req = 1'b1; mem_sel = 1'b1;
    repeat (6) @(posedge clk);
    #1 check("R3 long pending", {sleep_on, acc_block, acc_invalid}, 3'b010);
    // R6: drop request from pending, back to normal without recovery
    @(negedge clk); sleep_req = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R6 pending drop", {sleep_on, acc_block, acc_invalid}, 3'b000);

    // R1: reset in the middle of sleep
    @(negedge clk); mem_sel = 1'b0; sleep_req = 1'b1;
    repeat (5) @(posedge clk);
    #1 check("R2 re-entry", {sleep_on, acc_block, acc_invalid}, 3'b110);
    @(negedge clk); rst_n = 1'b0; sleep_req = 1'b0;
    @(posedge clk);
    #1 check("R1 reset mid-sleep", {sleep_on, acc_block, acc_invalid}, 3'b000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule